// File: doc/BRIEF.md
# Up-Counting Interval Timer with Posted Register Writes

This block is a register-mapped 32-bit timer for a processor subsystem. A counter runs upward on the core clock, either every cycle or, with the divider enabled, once every power-of-two number of cycles. When the counter rolls over from all-ones to zero it raises an overflow event and either continues from zero or reloads from a software-held load value. A compare value can raise a second event when the counter reaches it. Both events are latched in a write-1-to-clear status register and combined with per-event enables into a single level interrupt.

Writes to the registers that steer the counting logic (control, counter, load, reload strobe and compare value) are posted: each such register has its own pending flag that stays high for a fixed three cycles and only then does the new value reach the counting logic. Software polls the pending flags before depending on a write. A typical use arms a one-shot or periodic tick by writing the negated interval into the counter, so that the overflow fires after exactly that many counts.

Register offsets (byte addresses on the 8-bit address bus): revision 0x00, event status 0x18, event enable 0x1C, control 0x24, counter 0x28, load 0x2C, reload strobe 0x30, posting status 0x34, compare value 0x38. Every other offset reads as zero and ignores writes.

Top module: `upcount_timer`

## Requirements
- R1: After reset the control, counter, load, compare, status, enable and posting registers all read 0, the interrupt is low, and offset 0x00 reads the revision parameter (default 0x21: major 2 in bits 7:4, minor 1 in bits 3:0).
- R2: With control bit 0 (run) set and control bit 5 (divider enable) clear, the counter rises by exactly one per clock; with run clear it holds its value.
- R3: On a count from 0xFFFFFFFF the overflow status bit (bit 1 of 0x18) is set and the counter becomes the load value when control bit 1 (reload-on-overflow) is set, or 0 when it is clear.
- R4: With run and divider enable set and control bits 4:2 holding p, the counter advances once every 2^(p+1) clocks.
- R5: With control bit 6 (compare enable) set, the match status bit (bit 0 of 0x18) is set when a count step gives the counter the compare value.
- R6: A write to control, counter, load, reload strobe or compare sets posting bit 0, 1, 2, 3 or 4 of 0x34 for 3 clocks; the new value takes effect in the counting logic at the third clock edge after the write, and a repeated write restarts the wait.
- R7: A write of any data to the reload strobe (0x30) copies the load value into the counter when it takes effect.
- R8: Writing 0x18 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R9: The interrupt is high exactly when some status bit is set whose enable bit in 0x1C (same bit layout as 0x18, written without posting) is set.
- R10: Writing 2^32-N to the counter with reload-on-overflow and a load value of 0 makes the overflow interrupt rise after N counts, and counting then resumes from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all counting and register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq | output | 1 | Level interrupt, OR of enabled status bits |

## Verification
The counter is driven with a negated interval under reload-on-overflow, which separates a correct overflow count from an off-by-one in the arming or posting delay; a near-all-ones value without reload, which tells reload-to-load from wrap-to-zero; a divided clock, whose step over a fixed window tells the divider period from the undivided rate; and a compare value reached by stepping, with its enable both off and on, which separates event latching from interrupt gating. Back-to-back writes to one posted register and a reload strobe with the counter stopped show when posted values land. A behavioural model of the register file is compared with the read data and interrupt on every clock.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // register byte offsets
  localparam int OFF_REV    = 'h00;
  localparam int OFF_STAT   = 'h18;
  localparam int OFF_ENA    = 'h1C;
  localparam int OFF_CTRL   = 'h24;
  localparam int OFF_COUNT  = 'h28;
  localparam int OFF_LOAD   = 'h2C;
  localparam int OFF_STROBE = 'h30;
  localparam int OFF_POST   = 'h34;
  localparam int OFF_CMP    = 'h38;

  // posted-register slots; the index is the bit in the posting status
  localparam int SLOT_CTRL   = 0;
  localparam int SLOT_COUNT  = 1;
  localparam int SLOT_LOAD   = 2;
  localparam int SLOT_STROBE = 3;
  localparam int SLOT_CMP    = 4;
  localparam int NUM_SLOTS   = 5;

  // event / status bit positions
  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_CAPT  = 2;
  localparam int NUM_EV   = 3;

  function automatic int slot_offset(input int idx);
    case (idx)
      SLOT_CTRL:   return OFF_CTRL;
      SLOT_COUNT:  return OFF_COUNT;
      SLOT_LOAD:   return OFF_LOAD;
      SLOT_STROBE: return OFF_STROBE;
      default:     return OFF_CMP;
    endcase
  endfunction

  // clocks per count step with the divider on
  function automatic int unsigned divider_period(input int unsigned p);
    return 32'd1 << (p + 1);
  endfunction

endpackage

// File: rtl/post_slot.sv
module post_slot #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  output logic pending_o,
  output logic apply_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wait_q <= '0;
    else if (wr_i)         wait_q <= CW'(LAT);
    else if (wait_q != '0) wait_q <= wait_q - CW'(1);
  end

  assign pending_o = (wait_q != '0);
  assign apply_o   = (wait_q == CW'(1));

  AST_PEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pending_o && !apply_o); // R6
  AST_APPLY_ONLY_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |-> $past(pending_o)); // R6

endmodule

// File: rtl/count_core.sv
module count_core
  import timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          div_en_i,
  input  logic [PW-1:0] div_sel_i,
  input  logic          reload_ovf_i,
  input  logic          cmp_en_i,
  input  logic [DW-1:0] load_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          set_i,
  input  logic [DW-1:0] set_val_i,
  input  logic          strobe_i,
  output logic [DW-1:0] count_o,
  output logic          tick_o,
  output logic          ovf_o,
  output logic          match_o
);
  localparam int PCW = 2 ** PW;

  logic [DW-1:0]  count_q, step_val;
  logic [PCW-1:0] div_q, div_mask;
  logic           forced, at_top;

  assign forced   = set_i || strobe_i;
  assign div_mask = PCW'(divider_period(32'(div_sel_i)) - 1);
  assign at_top   = (count_q == '1);

  always_comb begin
    if (!run_i)        tick_o = 1'b0;
    else if (!div_en_i) tick_o = 1'b1;
    else               tick_o = (div_q == div_mask);
  end

  always_comb begin
    if (at_top) step_val = reload_ovf_i ? load_i : '0;
    else        step_val = count_q + DW'(1);
  end

  assign ovf_o   = tick_o && !forced && at_top;
  assign match_o = tick_o && !forced && cmp_en_i && (step_val == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            div_q <= '0;
    else if (!run_i || !div_en_i || forced) div_q <= '0;
    else if (tick_o)                       div_q <= '0;
    else                                   div_q <= div_q + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (set_i)    count_q <= set_val_i;
    else if (strobe_i) count_q <= load_i;
    else if (tick_o)   count_q <= step_val;
  end

  assign count_o = count_q;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !forced) |=> $stable(count_o)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !forced && !ovf_o) |=> count_o == $past(count_o) + DW'(1)); // R2
  AST_WRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> count_o == ($past(reload_ovf_i) ? $past(load_i) : '0)); // R3
  AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !set_i) |=> count_o == $past(load_i)); // R7

endmodule

// File: rtl/event_irq.sv
module event_irq #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           clr_we_i,
  input  logic           ena_we_i,
  input  logic [NEV-1:0] wdata_i,
  output logic [NEV-1:0] status_o,
  output logic [NEV-1:0] enable_o,
  output logic           irq_o
);
  logic [NEV-1:0] status_q, enable_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        enable_q <= '0;
    else if (ena_we_i) enable_q <= wdata_i;
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = |(status_q & enable_q);

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> (status_o & $past(evt_i)) == $past(evt_i)); // R5
  AST_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && evt_i == '0) |=> (status_o & $past(wdata_i)) == '0); // R8
  AST_KEEP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> (status_o & ~$past(wdata_i)) == ($past(status_o) & ~$past(wdata_i))); // R8

endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
  import timer_pkg::*;
#(
  parameter int          DW  = 32,
  parameter int          AW  = 8,
  parameter int          PW  = 3,
  parameter int          LAT = 3,
  parameter logic [7:0]  REV = 8'h21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  // control layout: run, reload-on-overflow, divider select, divider enable, compare enable
  localparam int CB_RUN    = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_SEL_LO = 2;
  localparam int CB_DIV    = CB_SEL_LO + PW;
  localparam int CB_CMP    = CB_DIV + 1;
  localparam int CTRL_W    = CB_CMP + 1;

  logic [NUM_SLOTS-1:0] slot_wr, slot_pend, slot_apply;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
      assign slot_wr[gi] = bus_we && (bus_addr == AW'(slot_offset(gi)));
      post_slot #(.LAT(LAT)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (slot_wr[gi]),
        .pending_o(slot_pend[gi]),
        .apply_o  (slot_apply[gi])
      );
    end
  endgenerate

  // holding registers for posted data, effective registers behind them
  logic [CTRL_W-1:0] ctrl_hold, ctrl_q;
  logic [DW-1:0]     count_hold, load_hold, load_q, cmp_hold, cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_hold  <= '0;
      count_hold <= '0;
      load_hold  <= '0;
      cmp_hold   <= '0;
    end else begin
      if (slot_wr[SLOT_CTRL])  ctrl_hold  <= bus_wdata[CTRL_W-1:0];
      if (slot_wr[SLOT_COUNT]) count_hold <= bus_wdata;
      if (slot_wr[SLOT_LOAD])  load_hold  <= bus_wdata;
      if (slot_wr[SLOT_CMP])   cmp_hold   <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (slot_apply[SLOT_CTRL]) ctrl_q <= ctrl_hold;
      if (slot_apply[SLOT_LOAD]) load_q <= load_hold;
      if (slot_apply[SLOT_CMP])  cmp_q  <= cmp_hold;
    end
  end

  // named internal events
  logic [DW-1:0]     count_val;
  logic              tick_evt, ovf_evt, match_evt;
  logic [NUM_EV-1:0] evt_vec, status_val, enable_val;

  count_core #(.DW(DW), .PW(PW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ctrl_q[CB_RUN]),
    .div_en_i    (ctrl_q[CB_DIV]),
    .div_sel_i   (ctrl_q[CB_DIV-1:CB_SEL_LO]),
    .reload_ovf_i(ctrl_q[CB_RELOAD]),
    .cmp_en_i    (ctrl_q[CB_CMP]),
    .load_i      (load_q),
    .cmp_i       (cmp_q),
    .set_i       (slot_apply[SLOT_COUNT]),
    .set_val_i   (count_hold),
    .strobe_i    (slot_apply[SLOT_STROBE]),
    .count_o     (count_val),
    .tick_o      (tick_evt),
    .ovf_o       (ovf_evt),
    .match_o     (match_evt)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[EV_MATCH] = match_evt;
    evt_vec[EV_OVF]   = ovf_evt;
  end

  event_irq #(.NEV(NUM_EV)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_vec),
    .clr_we_i(bus_we && (bus_addr == AW'(OFF_STAT))),
    .ena_we_i(bus_we && (bus_addr == AW'(OFF_ENA))),
    .wdata_i (bus_wdata[NUM_EV-1:0]),
    .status_o(status_val),
    .enable_o(enable_val),
    .irq_o   (irq)
  );

  always_comb begin
    case (bus_addr)
      AW'(OFF_REV):   bus_rdata = DW'(REV);
      AW'(OFF_STAT):  bus_rdata = DW'(status_val);
      AW'(OFF_ENA):   bus_rdata = DW'(enable_val);
      AW'(OFF_CTRL):  bus_rdata = DW'(ctrl_q);
      AW'(OFF_COUNT): bus_rdata = count_val;
      AW'(OFF_LOAD):  bus_rdata = load_q;
      AW'(OFF_POST):  bus_rdata = DW'(slot_pend);
      AW'(OFF_CMP):   bus_rdata = cmp_q;
      default:        bus_rdata = '0;
    endcase
  end

  AST_OVF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> tick_evt && ctrl_q[CB_RUN]); // R3
  AST_IRQ_FOLLOWS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && enable_val[EV_OVF] && !bus_we) |=> irq); // R9
  AST_POST_NO_EARLY_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr[SLOT_LOAD] |=> $stable(load_q)); // R6

endmodule

// File: tb/upcount_timer_bench.sv
`timescale 1ns/1ps
module upcount_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h28;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk; // 125 MHz

  upcount_timer u_upcount_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt, m_load, m_cmp, h_cnt, h_load, h_cmp;
  logic [6:0]  m_ctrl, h_ctrl;
  logic [2:0]  m_st, m_en;
  int          m_pend [5];
  int          m_div;

  function automatic logic [7:0] addr_of(input int k);
    case (k)
      0: return 8'h24; 1: return 8'h28; 2: return 8'h2C; 3: return 8'h30; default: return 8'h38;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] p;
    p = '0;
    for (int k = 0; k < 5; k++) if (m_pend[k] > 0) p[k] = 1'b1;
    case (a)
      8'h00: return 32'h21;
      8'h18: return {29'd0, m_st};
      8'h1C: return {29'd0, m_en};
      8'h24: return {25'd0, m_ctrl};
      8'h28: return m_cnt;
      8'h2C: return m_load;
      8'h34: return p;
      8'h38: return m_cmp;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_cmp = 0; m_ctrl = 0; m_st = 0; m_en = 0; m_div = 0;
      h_cnt = 0; h_load = 0; h_cmp = 0; h_ctrl = 0;
      for (int k = 0; k < 5; k++) m_pend[k] = 0;
    end else begin
      bit app [5];
      bit tk, ovf, mat, run, dv;
      int per, nd;
      logic [31:0] nc;
      for (int k = 0; k < 5; k++) app[k] = (m_pend[k] == 1);
      run = m_ctrl[0]; dv = m_ctrl[5];
      tk = 0; per = 1 << (int'(m_ctrl[4:2]) + 1);
      if (run && !dv) tk = 1;
      else if (run) tk = (m_div == per - 1);
      nd = 0;
      if (run && dv && !app[1] && !app[3]) nd = tk ? 0 : m_div + 1;
      nc = m_cnt; ovf = 0; mat = 0;
      if (app[1]) nc = h_cnt;
      else if (app[3]) nc = m_load;
      else if (tk) begin
        if (m_cnt == 32'hFFFF_FFFF) begin ovf = 1; nc = m_ctrl[1] ? m_load : 32'd0; end
        else nc = m_cnt + 1;
        if (m_ctrl[6] && nc == m_cmp) mat = 1;
      end
      if (bus_we && bus_addr == 8'h18) m_st = m_st & ~bus_wdata[2:0];
      m_st = m_st | {1'b0, ovf, mat};
      if (bus_we && bus_addr == 8'h1C) m_en = bus_wdata[2:0];
      if (app[0]) m_ctrl = h_ctrl;
      if (app[2]) m_load = h_load;
      if (app[4]) m_cmp = h_cmp;
      m_cnt = nc; m_div = nd;
      for (int k = 0; k < 5; k++) begin
        if (bus_we && bus_addr == addr_of(k)) begin
          m_pend[k] = 3;
          case (k)
            0: h_ctrl = bus_wdata[6:0];
            1: h_cnt = bus_wdata;
            2: h_load = bus_wdata;
            4: h_cmp = bus_wdata;
            default: ;
          endcase
        end else if (m_pend[k] > 0) m_pend[k] = m_pend[k] - 1;
      end
    end
  end

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h28: return "R2";
      8'h18: return "R8";
      8'h34: return "R6";
      8'h2C, 8'h38, 8'h24: return "R6";
      default: return "R1";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== model_read(bus_addr)) begin
        failures++;
        $display("FAIL %s per-cycle read addr=%h actual=%h expected=%h",
                 tag_of(bus_addr), bus_addr, bus_rdata, model_read(bus_addr));
      end
      checks++;
      if (irq !== |(m_st & m_en)) begin
        failures++;
        $display("FAIL R9 per-cycle irq actual=%0b expected=%0b", irq, |(m_st & m_en));
      end
    end
  end

  // ---------------- named checks ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h28;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, a0, a1;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); chk("R1", "revision", v, 32'h21);
    rd(8'h24, v); chk("R1", "control at reset", v, 32'h0);
    rd(8'h28, v); chk("R1", "counter at reset", v, 32'h0);
    rd(8'h18, v); chk("R1", "status at reset", v, 32'h0);
    chk("R1", "irq at reset", {31'd0, irq}, 32'h0);

    // R6: posting flag on a counter write, value lands after 3 edges
    wr(8'h1C, 32'h2);
    wr(8'h28, 32'hFFFF_FFF6);            // arm: 2^32 - 10
    rd(8'h34, v); chk("R6", "counter pending right after write", v, 32'h2);
    rd(8'h28, v); chk("R6", "counter not yet changed", v, 32'h0);
    // R10: run with reload-on-overflow, load 0
    wr(8'h24, 32'h3);
    n = 0;
    while (!irq && n < 100) begin @(posedge clk); #1; n++; end
    chk("R10", "edges from control write to overflow irq (3 + N)", n, 32'd13);
    @(negedge clk);
    rd(8'h28, v); chk("R3", "counter restarts from load 0", v, 32'h0);
    rd(8'h18, v); chk("R3", "overflow status bit", v, 32'h2);

    // R8: write-one-to-clear
    wr(8'h18, 32'h0);
    rd(8'h18, v); chk("R8", "zero write keeps status", v, 32'h2);
    wr(8'h18, 32'h2);
    rd(8'h18, v); chk("R8", "one write clears status", v, 32'h0);
    chk("R9", "irq drops after clear", {31'd0, irq}, 32'h0);

    // R4: divider, p=1 -> every 4 clocks
    wr(8'h24, 32'h25);
    idle(6);
    rd(8'h28, a0); idle(16); rd(8'h28, a1);
    chk("R4", "steps over 16 clocks with period 4", a1 - a0, 32'd4);

    // R2: stopped counter holds
    wr(8'h24, 32'h0);
    idle(4);
    rd(8'h28, a0); idle(10); rd(8'h28, a1);
    chk("R2", "stopped counter holds", a1, a0);
    // R2: undivided rate
    wr(8'h24, 32'h1);
    idle(4);
    rd(8'h28, a0); idle(10); rd(8'h28, a1);
    chk("R2", "ten steps in ten clocks", a1 - a0, 32'd10);

    // R5 / R9: compare
    wr(8'h24, 32'h0);
    wr(8'h28, 32'd100);
    wr(8'h38, 32'd105);
    wr(8'h24, 32'h41);
    idle(20);
    rd(8'h18, v); chk("R5", "match status set", v, 32'h1);
    chk("R9", "match not enabled keeps irq low", {31'd0, irq}, 32'h0);
    wr(8'h1C, 32'h1);
    chk("R9", "enabling match raises irq", {31'd0, irq}, 32'h1);

    // R7: reload strobe with counter stopped
    wr(8'h24, 32'h0);
    wr(8'h18, 32'h7);
    idle(4);
    wr(8'h2C, 32'h1234);
    wr(8'h30, 32'hDEAD_BEEF);
    idle(4);
    rd(8'h28, v); chk("R7", "strobe copies load into counter", v, 32'h1234);

    // R3: wrap without reload goes to 0, not load
    wr(8'h28, 32'hFFFF_FFFE);
    wr(8'h24, 32'h1);
    idle(12);
    wr(8'h24, 32'h0);
    idle(4);
    rd(8'h28, v); chk("R3", "wrap without reload lands near 0", {31'd0, v < 32'h20}, 32'h1);
    rd(8'h18, v); chk("R3", "overflow flagged on plain wrap", v & 32'h2, 32'h2);

    // R6: repeated write restarts the wait
    wr(8'h38, 32'd7);
    wr(8'h38, 32'd9);
    idle(2);
    rd(8'h34, v); chk("R6", "compare still pending after restart", v, 32'h10);
    idle(2);
    rd(8'h34, v); chk("R6", "posting clear", v, 32'h0);
    rd(8'h38, v); chk("R6", "last compare value applied", v, 32'd9);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule